// File: doc/BRIEF.md
# GPIO Interrupt Controller

This block is a register-mapped general-purpose I/O controller for 94 pins. Software reaches every register through a single-cycle synchronous read/write port with byte addressing. Each pin has two private configuration words. The first word selects GPIO or native use, the direction, the driven level and the interrupt trigger. The second word holds an input-sensing disable bit and a two-bit weak-pull code, which is stored but drives no logic here. Shared bitmapped words hold pin ownership, interrupt enable and interrupt status at 32 pins per word. There is also one general control word that is read and written as plain storage.

Every pin input passes through a two-flop synchronizer. A trigger stage then raises an event on a rising edge, a falling edge, a low level or a high level. Each event sets a sticky status bit, and software clears that bit by writing a one to it. The status bits are masked by the enable bits and by ownership, and the result is ORed into one interrupt line. Pins whose ownership bit is clear are held back for firmware: they never drive their output and never record events.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Register map, all addresses 4-byte aligned, with word k covering pins 32k..32k+31. Ownership is at 0x00+4k, the control word at 0x7C, status at 0x80+4k, enable at 0x90+4k, configuration word 1 of pin n at 0x100+8n and configuration word 2 at 0x104+8n. Read data appears on reg_rdata in the cycle after reg_rd and holds until the next read. Misaligned or unmapped addresses read as 0 and ignore writes. Bits for pins at 94 and above read 0.
- R2: After reset, ownership reads 1 for every existing pin, and all configuration, enable, status and control bits read 0.
- R3: Configuration word 1 stores bit 31 (output level), bit 4 (trigger select), bit 3 (invert), bit 2 (direction, 1 = input) and bit 0 (use, 1 = GPIO). pin_oe[n] is 1 only when the pin is owned, use is 1 and direction is 0. pin_out[n] equals bit 31 while pin_oe[n] is 1 and is 0 otherwise.
- R4: Bit 30 of configuration word 1 reads the pin input after two synchronizing flops, so it shows the value presented before clock edge k once edge k+1 has passed. It reads 0 while bit 2 of word 2 (sense disable) is 1. Writes to bit 30 have no effect. Word 2 stores bits 2:0.
- R5: The pair {bit 4, bit 3} selects the trigger: 00 rising edge, 01 falling edge, 10 low level, 11 high level. An edge presented before clock edge k sets the pin's status bit at edge k+2.
- R6: In level modes the status bit is set again on every cycle that the synchronized level stays active, even right after a clear.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a clear and a new event hit the same pin in the same cycle, the bit stays set.
- R8: irq_out is 1 exactly when some pin is owned, has its enable bit set and has its status bit set.
- R9: A pin whose ownership bit is 0 never has its status bit set by an input event, and its pin_oe stays 0.
- R10: While sense disable is 1, the pin records no events. A pin whose level did not change while sensing was off records no edge when sensing is turned back on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| pin_in | input | 94 | Pin input levels |
| pin_out | output | 94 | Pin output levels |
| pin_oe | output | 94 | Pin output enables |
| irq_out | output | 1 | Aggregate interrupt |

## Verification
A wrong synchronizer or edge-history bit appears at the ports as a status bit, and an interrupt, that comes one cycle early, one cycle late, or not at all. That difference is visible on irq_out within three cycles of the input change. A status bit that sticks wrongly or is lost shows up on the next read of its status word, and on irq_out at once if the pin is enabled. A corrupted configuration or ownership bit changes pin_oe or pin_out in the same cycle. The bench therefore compares irq_out, pin_oe, pin_out and reg_rdata against its own model on every cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Bitmapped region bases (byte offsets)
  localparam int unsigned OFS_OWN  = 32'h000;
  localparam int unsigned OFS_CTRL = 32'h07C;
  localparam int unsigned OFS_STAT = 32'h080;
  localparam int unsigned OFS_EN   = 32'h090;
  // Per-pin configuration base, two words per pin
  localparam int unsigned OFS_CFG  = 32'h100;
  localparam int unsigned CFG_STRIDE = 8;

  // Configuration word 1 bit positions
  localparam int B_OUT  = 31;
  localparam int B_IN   = 30;
  localparam int B_TRIG = 4;
  localparam int B_INV  = 3;
  localparam int B_DIR  = 2;
  localparam int B_USE  = 0;
  // Configuration word 2 bit positions
  localparam int B_DIS  = 2;

  typedef struct packed {
    logic       out_lvl;
    logic       trig_lvl;
    logic       inv;
    logic       dir_in;
    logic       use_gpio;
    logic       sense_dis;
    logic [1:0] pull;
  } pin_cfg_t;

endpackage

// File: rtl/gpio_sense.sv
module gpio_sense #(
  parameter int NUM_PINS = 94
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] trig_lvl,
  input  logic [NUM_PINS-1:0] inv,
  input  logic [NUM_PINS-1:0] sense_dis,
  input  logic [NUM_PINS-1:0] own,
  output logic [NUM_PINS-1:0] lvl,
  output logic [NUM_PINS-1:0] evt
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic s1_q, s2_q, prev_q;

    // Two-flop synchronizer plus one history flop for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= pin_in[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end

    logic hit;
    always_comb begin
      unique case ({trig_lvl[g], inv[g]})
        2'b00:   hit = s2_q & ~prev_q;
        2'b01:   hit = ~s2_q & prev_q;
        2'b10:   hit = ~s2_q;
        default: hit = s2_q;
      endcase
      evt[g] = hit & ~sense_dis[g] & own[g];
      lvl[g] = s2_q & ~sense_dis[g];
    end
  end

endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
  parameter int NUM_PINS = 94
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] evt,
  input  logic [NUM_PINS-1:0] clr,
  output logic [NUM_PINS-1:0] status
);

  logic [NUM_PINS-1:0] status_q, status_d;

  // New events override a same-cycle clear
  always_comb begin
    status_d = (status_q & ~clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status = status_q;

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((($past(status_q) & ~$past(clr))) & ~status_q) == '0)); // R7
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt) & ~status_q) == '0)); // R7

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 94,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  input  logic [NUM_PINS-1:0] in_lvl,
  input  logic [NUM_PINS-1:0] status,
  output logic [NUM_PINS-1:0] own,
  output logic [NUM_PINS-1:0] en,
  output logic [NUM_PINS-1:0] clr_mask,
  output logic [NUM_PINS-1:0] out_lvl,
  output logic [NUM_PINS-1:0] trig_lvl,
  output logic [NUM_PINS-1:0] inv,
  output logic [NUM_PINS-1:0] dir_in,
  output logic [NUM_PINS-1:0] use_gpio,
  output logic [NUM_PINS-1:0] sense_dis,
  output logic [31:0]         rdata
);

  localparam int NWORDS   = (NUM_PINS + 31) / 32;
  localparam int BM_SPAN  = NWORDS * 4;
  localparam int CFG_SPAN = NUM_PINS * CFG_STRIDE;
  localparam int WI       = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int PI       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                  input int unsigned base,
                                  input int unsigned span);
    int unsigned av;
    av = 32'(a);
    return (av >= base) && (av < base + span);
  endfunction

  logic [NUM_PINS-1:0] own_q, own_d, en_q, en_d;
  logic [31:0]         ctrl_q, ctrl_d;
  pin_cfg_t            cfg_q [NUM_PINS];
  pin_cfg_t            cfg_d [NUM_PINS];
  logic [31:0]         rdata_q, rd_val;

  // Address decode
  logic aligned, hit_own, hit_ctrl, hit_stat, hit_en, hit_cfg, sub_w2;
  logic [ADDR_W-1:0] bm_rel, cfg_rel;
  logic [WI-1:0]     widx;
  logic [PI-1:0]     pidx;

  always_comb begin
    aligned  = (addr[1:0] == 2'b00);
    hit_own  = aligned & in_win(addr, OFS_OWN, BM_SPAN);
    hit_ctrl = aligned & (addr == ADDR_W'(OFS_CTRL));
    hit_stat = aligned & in_win(addr, OFS_STAT, BM_SPAN);
    hit_en   = aligned & in_win(addr, OFS_EN, BM_SPAN);
    hit_cfg  = aligned & in_win(addr, OFS_CFG, CFG_SPAN);
    bm_rel   = hit_stat ? (addr - ADDR_W'(OFS_STAT)) :
               hit_en   ? (addr - ADDR_W'(OFS_EN))   :
                          (addr - ADDR_W'(OFS_OWN));
    widx     = WI'(bm_rel >> 2);
    cfg_rel  = addr - ADDR_W'(OFS_CFG);
    pidx     = PI'(cfg_rel >> 3);
    sub_w2   = cfg_rel[2];
  end

  // Next-state for writable storage
  always_comb begin
    own_d    = own_q;
    en_d     = en_q;
    ctrl_d   = ctrl_q;
    cfg_d    = cfg_q;
    clr_mask = '0;
    if (wr_en) begin
      if (hit_ctrl) ctrl_d = wdata;
      for (int b = 0; b < NUM_PINS; b++) begin
        if (b / 32 == int'(widx)) begin
          if (hit_own)  own_d[b]    = wdata[b % 32];
          if (hit_en)   en_d[b]     = wdata[b % 32];
          if (hit_stat) clr_mask[b] = wdata[b % 32];
        end
      end
      if (hit_cfg) begin
        if (!sub_w2) begin
          cfg_d[pidx].out_lvl  = wdata[B_OUT];
          cfg_d[pidx].trig_lvl = wdata[B_TRIG];
          cfg_d[pidx].inv      = wdata[B_INV];
          cfg_d[pidx].dir_in   = wdata[B_DIR];
          cfg_d[pidx].use_gpio = wdata[B_USE];
        end else begin
          cfg_d[pidx].sense_dis = wdata[B_DIS];
          cfg_d[pidx].pull      = wdata[1:0];
        end
      end
    end
  end

  // Read mux
  always_comb begin
    rd_val = '0;
    if (hit_ctrl) rd_val = ctrl_q;
    for (int b = 0; b < NUM_PINS; b++) begin
      if (b / 32 == int'(widx)) begin
        if (hit_own)  rd_val[b % 32] = own_q[b];
        if (hit_en)   rd_val[b % 32] = en_q[b];
        if (hit_stat) rd_val[b % 32] = status[b];
      end
    end
    if (hit_cfg) begin
      if (!sub_w2) begin
        rd_val[B_OUT]  = cfg_q[pidx].out_lvl;
        rd_val[B_IN]   = in_lvl[pidx];
        rd_val[B_TRIG] = cfg_q[pidx].trig_lvl;
        rd_val[B_INV]  = cfg_q[pidx].inv;
        rd_val[B_DIR]  = cfg_q[pidx].dir_in;
        rd_val[B_USE]  = cfg_q[pidx].use_gpio;
      end else begin
        rd_val[B_DIS]  = cfg_q[pidx].sense_dis;
        rd_val[1:0]    = cfg_q[pidx].pull;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q   <= '1;
      en_q    <= '0;
      ctrl_q  <= '0;
      rdata_q <= '0;
      for (int i = 0; i < NUM_PINS; i++) cfg_q[i] <= '0;
    end else begin
      own_q  <= own_d;
      en_q   <= en_d;
      ctrl_q <= ctrl_d;
      for (int i = 0; i < NUM_PINS; i++) cfg_q[i] <= cfg_d[i];
      if (rd_en) rdata_q <= rd_val;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_unpack
    assign out_lvl[g]   = cfg_q[g].out_lvl;
    assign trig_lvl[g]  = cfg_q[g].trig_lvl;
    assign inv[g]       = cfg_q[g].inv;
    assign dir_in[g]    = cfg_q[g].dir_in;
    assign use_gpio[g]  = cfg_q[g].use_gpio;
    assign sense_dis[g] = cfg_q[g].sense_dis;
  end

  assign own   = own_q;
  assign en    = en_q;
  assign rdata = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q)); // R1

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NUM_PINS = 94,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_out
);

  // Reset: asynchronous assert, synchronous release
  logic rst_meta, rst_core;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_core <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_core <= rst_meta;
    end
  end

  logic [NUM_PINS-1:0] own_v, en_v, clr_v, out_v, trig_v, inv_v;
  logic [NUM_PINS-1:0] dir_v, use_v, dis_v, lvl_v, evt_v, status_v;

  gpio_regfile #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_regs (
    .clk      (clk),
    .rst_n    (rst_core),
    .wr_en    (reg_wr),
    .rd_en    (reg_rd),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .in_lvl   (lvl_v),
    .status   (status_v),
    .own      (own_v),
    .en       (en_v),
    .clr_mask (clr_v),
    .out_lvl  (out_v),
    .trig_lvl (trig_v),
    .inv      (inv_v),
    .dir_in   (dir_v),
    .use_gpio (use_v),
    .sense_dis(dis_v),
    .rdata    (reg_rdata)
  );

  gpio_sense #(.NUM_PINS(NUM_PINS)) i_sense (
    .clk      (clk),
    .rst_n    (rst_core),
    .pin_in   (pin_in),
    .trig_lvl (trig_v),
    .inv      (inv_v),
    .sense_dis(dis_v),
    .own      (own_v),
    .lvl      (lvl_v),
    .evt      (evt_v)
  );

  gpio_status #(.NUM_PINS(NUM_PINS)) i_status (
    .clk   (clk),
    .rst_n (rst_core),
    .evt   (evt_v),
    .clr   (clr_v),
    .status(status_v)
  );

  always_comb begin
    pin_oe  = own_v & use_v & ~dir_v;
    pin_out = out_v & pin_oe;
    irq_out = |(status_v & en_v & own_v);
  end

  AST_OWN_BLOCKS_EVENTS: assert property (@(posedge clk) disable iff (!rst_core)
    1'b1 |=> ((status_v & ~$past(status_v) & ~$past(own_v)) == '0)); // R9
  AST_SENSE_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_core)
    1'b1 |=> ((status_v & ~$past(status_v) & $past(dis_v)) == '0)); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_core)
    (status_v == '0) |-> !irq_out); // R8

endmodule

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;

  localparam int NP = 94;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  // ---------------- behavioural reference model ----------------
  logic [NP-1:0] m_s1, m_s2, m_pv, m_st, m_en, m_own;
  logic [NP-1:0] m_out, m_trig, m_inv, m_dir, m_use, m_dis;
  logic [1:0]    m_pull [NP];
  logic [31:0]   m_ctrl, m_rd;

  function automatic logic [31:0] mread(input logic [11:0] a);
    int ai;
    int p;
    logic [31:0] r;
    ai = int'(a);
    r = '0;
    if (ai % 4 != 0) return r;
    for (int b = 0; b < 32; b++) begin
      if (ai < 12)                p = (ai / 4) * 32 + b;
      else if (ai >= 128 && ai < 140) p = ((ai - 128) / 4) * 32 + b;
      else if (ai >= 144 && ai < 156) p = ((ai - 144) / 4) * 32 + b;
      else p = -1;
      if (p >= 0 && p < NP) begin
        if (ai < 12)       r[b] = m_own[p];
        else if (ai < 140) r[b] = m_st[p];
        else               r[b] = m_en[p];
      end
    end
    if (ai == 124) r = m_ctrl;
    if (ai >= 256 && ai < 256 + NP * 8) begin
      p = (ai - 256) / 8;
      if ((ai - 256) % 8 == 0)
        r = {m_out[p], m_s2[p] & ~m_dis[p], 25'd0, m_trig[p], m_inv[p], m_dir[p], 1'b0, m_use[p]};
      else
        r = {29'd0, m_dis[p], m_pull[p]};
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_pv = '0; m_st = '0; m_en = '0; m_own = '1;
      m_out = '0; m_trig = '0; m_inv = '0; m_dir = '0; m_use = '0; m_dis = '0;
      for (int i = 0; i < NP; i++) m_pull[i] = 2'b00;
      m_ctrl = '0; m_rd = '0;
    end else begin
      int ai;
      ai = int'(reg_addr);
      if (reg_rd) m_rd = mread(reg_addr);
      for (int p = 0; p < NP; p++) begin
        logic e, c;
        case ({m_trig[p], m_inv[p]})
          2'b00: e = m_s2[p] & ~m_pv[p];
          2'b01: e = ~m_s2[p] & m_pv[p];
          2'b10: e = ~m_s2[p];
          default: e = m_s2[p];
        endcase
        e = e & ~m_dis[p] & m_own[p];
        c = reg_wr && (ai == 128 + 4 * (p / 32)) && reg_wdata[p % 32];
        m_st[p] = (m_st[p] & ~c) | e;
      end
      m_pv = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      if (reg_wr && ai % 4 == 0) begin
        for (int p = 0; p < NP; p++) begin
          if (ai == 4 * (p / 32))       m_own[p] = reg_wdata[p % 32];
          if (ai == 144 + 4 * (p / 32)) m_en[p]  = reg_wdata[p % 32];
        end
        if (ai == 124) m_ctrl = reg_wdata;
        if (ai >= 256 && ai < 256 + NP * 8) begin
          int p;
          p = (ai - 256) / 8;
          if ((ai - 256) % 8 == 0) begin
            m_out[p] = reg_wdata[31]; m_trig[p] = reg_wdata[4]; m_inv[p] = reg_wdata[3];
            m_dir[p] = reg_wdata[2];  m_use[p]  = reg_wdata[0];
          end else begin
            m_dis[p] = reg_wdata[2]; m_pull[p] = reg_wdata[1:0];
          end
        end
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [NP-1:0] e_oe;
      logic          e_irq;
      e_oe  = m_own & m_use & ~m_dir;
      e_irq = |(m_st & m_en & m_own);
      checks += 4;
      if (irq_out !== e_irq) begin
        errors++; $display("FAIL R8 irq_out actual=%0b expected=%0b t=%0t", irq_out, e_irq, $time);
      end
      if (pin_oe !== e_oe) begin
        errors++; $display("FAIL R3 pin_oe actual=%h expected=%h t=%0t", pin_oe, e_oe, $time);
      end
      if (pin_out !== (m_out & e_oe)) begin
        errors++; $display("FAIL R3 pin_out actual=%h expected=%h t=%0t", pin_out, m_out & e_oe, $time);
      end
      if (reg_rdata !== m_rd) begin
        errors++; $display("FAIL R1 reg_rdata actual=%h expected=%h t=%0t", reg_rdata, m_rd, $time);
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic setpin(input int p, input logic v);
    @(negedge clk); pin_in[p] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] c1(input int p); return 12'(256 + 8 * p); endfunction
  function automatic logic [11:0] c2(input int p); return 12'(260 + 8 * p); endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0; pin_in = '0;
    idle(4);
    rst_n = 1'b1;
    idle(5);
    cmp_on = 1'b1;

    // R2: reset values
    rd(12'h000, v); chk("R2 own word0", v, 32'hFFFF_FFFF);
    rd(12'h008, v); chk("R2 own word2", v, 32'h3FFF_FFFF);
    rd(12'h090, v); chk("R2 enable word0", v, 32'h0);
    rd(12'h084, v); chk("R2 status word1", v, 32'h0);
    rd(c1(5), v);   chk("R2 cfg1 pin5", v, 32'h0);
    chk("R2 irq_out", 32'(irq_out), 32'h0);

    // R1: map and readback
    wr(c1(93), 32'hC000_001F); rd(c1(93), v); chk("R1 cfg1 pin93 readback", v, 32'h8000_001D);
    wr(c2(93), 32'hFFFF_FFFF); rd(c2(93), v); chk("R1 cfg2 pin93 readback", v, 32'h7);
    wr(c2(93), 32'h0);
    wr(12'h07C, 32'h1234_5678); rd(12'h07C, v); chk("R1 control word", v, 32'h1234_5678);
    rd(12'h102, v); chk("R1 misaligned read", v, 32'h0);
    wr(12'h040, 32'hFFFF_FFFF); rd(12'h040, v); chk("R1 unmapped read", v, 32'h0);

    // R3: output enable and level
    wr(c1(3), 32'h8000_0001); idle(1);
    chk("R3 oe pin3", 32'(pin_oe[3]), 32'h1); chk("R3 out pin3", 32'(pin_out[3]), 32'h1);
    wr(c1(3), 32'h8000_0005); idle(1);
    chk("R3 oe pin3 input dir", 32'(pin_oe[3]), 32'h0);
    wr(c1(3), 32'h8000_0000); idle(1);
    chk("R3 oe pin3 native", 32'(pin_oe[3]), 32'h0);

    // R4: sampled input level and sense disable
    setpin(7, 1'b1); idle(2);
    rd(c1(7), v); chk("R4 input level pin7", v, 32'h4000_0000);
    wr(c2(7), 32'h4); rd(c1(7), v); chk("R4 sense disabled level", v, 32'h0);
    wr(c2(7), 32'h0);
    wr(12'h080, 32'hFFFF_FFFF); wr(12'h084, 32'hFFFF_FFFF); wr(12'h088, 32'hFFFF_FFFF);

    // R5: rising edge, pin 10
    wr(12'h090, 32'h0000_0400);
    setpin(10, 1'b1); idle(2);
    chk("R5 rising not before edge k+2", 32'(irq_out), 32'h0);
    idle(1);
    chk("R5 rising sets irq", 32'(irq_out), 32'h1);
    rd(12'h080, v); chk("R5 rising status", v, 32'h0000_0400);
    // R7: write zero keeps, write one clears
    wr(12'h080, 32'h0); rd(12'h080, v); chk("R7 zero write keeps", v, 32'h0000_0400);
    wr(12'h080, 32'h0000_0400); rd(12'h080, v); chk("R7 one write clears", v, 32'h0);
    // R5: falling
    wr(c1(10), 32'h8); setpin(10, 1'b0); idle(3);
    rd(12'h080, v); chk("R5 falling status", v, 32'h0000_0400);
    wr(12'h080, 32'h0000_0400);
    // R6: level low keeps reasserting
    wr(c1(10), 32'h10); idle(2);
    wr(12'h080, 32'h0000_0400); rd(12'h080, v); chk("R6 low level survives clear", v, 32'h0000_0400);
    setpin(10, 1'b1); idle(3); wr(12'h080, 32'h0000_0400);
    rd(12'h080, v); chk("R6 low level inactive clears", v, 32'h0);
    // R5/R6: level high
    wr(c1(10), 32'h18); idle(2);
    rd(12'h080, v); chk("R5 high level status", v, 32'h0000_0400);
    setpin(10, 1'b0); wr(c1(10), 32'h0); idle(3); wr(12'h080, 32'hFFFF_FFFF);
    wr(12'h090, 32'h0);

    // R8: third word, masking by enable
    setpin(70, 1'b1); idle(3);
    rd(12'h088, v); chk("R5 pin70 status word2", v, 32'h0000_0040);
    chk("R8 disabled pin no irq", 32'(irq_out), 32'h0);
    wr(12'h098, 32'h0000_0040); idle(1);
    chk("R8 enabled pin irq", 32'(irq_out), 32'h1);
    wr(12'h088, 32'h0000_0040); idle(1);
    chk("R8 cleared irq", 32'(irq_out), 32'h0);

    // R10: sensing disabled
    wr(c2(20), 32'h4); setpin(20, 1'b1); idle(3);
    rd(12'h080, v); chk("R10 no event while disabled", v & 32'h0010_0000, 32'h0);
    wr(c2(20), 32'h0); idle(2);
    rd(12'h080, v); chk("R10 no edge on re-enable", v & 32'h0010_0000, 32'h0);

    // R9: firmware-owned pin
    wr(12'h000, 32'hFDFF_FFFF); wr(12'h090, 32'h0200_0000); wr(c1(25), 32'h8000_0001);
    setpin(25, 1'b1); idle(3);
    rd(12'h080, v); chk("R9 unowned pin no status", v & 32'h0200_0000, 32'h0);
    chk("R9 unowned pin no oe", 32'(pin_oe[25]), 32'h0);
    chk("R9 unowned pin no irq", 32'(irq_out), 32'h0);
    wr(12'h000, 32'hFFFF_FFFF);

    // Mixed traffic, checked per cycle against the model
    for (int it = 0; it < 3000; it++) begin
      int pins [7] = '{0, 1, 31, 32, 63, 64, 93};
      int p;
      p = pins[$urandom_range(0, 6)];
      case ($urandom_range(0, 7))
        0: wr(c1(p), $urandom());
        1: wr(c2(p), $urandom() & 32'h0000_0003);
        2: wr(12'(144 + 4 * $urandom_range(0, 2)), $urandom());
        3: wr(12'(128 + 4 * $urandom_range(0, 2)), $urandom());
        4: begin
             logic [31:0] d;
             rd(c1(p), d);
           end
        5: begin
             logic [31:0] d;
             rd(12'(128 + 4 * $urandom_range(0, 2)), d);
           end
        6: if ($urandom_range(0, 9) == 0) wr(12'(4 * $urandom_range(0, 2)), $urandom() | 32'hF0F0_F0F0);
        default: setpin(p, ~pin_in[p]);
      endcase
    end
    idle(4);
    summary();
  end

endmodule